// File: doc/BRIEF.md
# Serial/Parallel Nibble Entry Register

This block is the entry stage in front of a nibble-wide fall-through queue. A nibble arrives in one of two ways. It can come as a 4-bit parallel word with a load strobe. It can also come as a bit stream: one bit moves in on each falling edge of a serial clock, while an active-low serial enable is asserted. The block holds the nibble and signals that it is full on an active-low flag. It then offers the nibble downstream on a valid/ready interface.

Fullness is not counted. After initialisation, a single marker bit sits in the top data stage. Each serial shift moves the marker down one stage. The marker drops into a fifth flag stage on exactly the fourth shift, and the flag stage is the full indication. A parallel load writes the flag stage directly. The serial clock is a plain signal sampled by the system clock, so a falling edge is seen when the clock was high at one system edge and low at the next.

Back-pressure rules: `out_valid` is high for as long as the register is full. The nibble on `out_data` stays stable while `out_ready` is low. On the edge where both are high, the nibble is handed over and the register re-initialises. With `out_ready` held high, each nibble therefore gives a one-cycle valid pulse.

Top module: `nibble_entry_reg`

## Requirements
- R1: After reset, `full_n` is 1, `out_valid` is 0, `proto_err` is 0 and `out_data` is 4'b1000: the marker is in bit 3 and bits 2..0 are zero.
- R2: When `par_load` is high at a clock edge, `out_data[i]` takes `par_data[i]` and `full_n` is low from the next cycle.
- R3: While `ser_en_n` is low and the register is not full, each sampled falling edge of `ser_clk` gives exactly one shift. The new bit enters bit 3 and the other stages move one place toward bit 0. Of four serial bits, the first ends in `out_data[0]` and the fourth in `out_data[3]`.
- R4: `full_n` goes low in the cycle after the fourth serial shift and not earlier. Before then, `out_data` shows the bits received so far in the top bits, followed by the marker.
- R5: While full, falling edges of `ser_clk` change neither `out_data` nor `full_n`.
- R6: While `ser_en_n` is high, falling edges of `ser_clk` change nothing.
- R7: `out_valid` equals the full state. While `out_ready` is low, the nibble is held. After a clock edge with `out_valid` and `out_ready` both high (and no load), the register is back in the R1 state.
- R8: When `par_load` coincides with a sampled `ser_clk` falling edge, the load wins and no shift occurs. `proto_err` is high for exactly the following cycle.
- R9: When `par_load` coincides with a handshake, the old nibble is taken, the new nibble is loaded, and the register stays full.
- R10: A synchronous `rst` at any point returns the register to the R1 state on the next edge, including in the middle of a serial nibble. The sampled serial clock is cleared too, so a clock that was low stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load | input | 1 | Parallel load strobe |
| par_data | input | 4 | Parallel nibble, bit i to stage i |
| ser_clk | input | 1 | Serial clock, sampled; shifts on its falling edge |
| ser_data | input | 1 | Serial data bit |
| ser_en_n | input | 1 | Active-low serial enable |
| full_n | output | 1 | Active-low full flag |
| out_valid | output | 1 | Nibble available downstream |
| out_ready | input | 1 | Downstream accepts the nibble |
| out_data | output | 4 | Held nibble (partial pattern while filling) |
| proto_err | output | 1 | One-cycle pulse on a load/serial-edge collision |

## Verification
If a stage or the marker is corrupted, the fault shows on `out_data` in the very next cycle: the nibble is visible on the port at every step of a serial fill. A marker that is lost or duplicated shows up as `full_n` falling one shift too early, or never falling at all. That error is visible no later than the fourth serial edge of the nibble. A wrong sampled-clock register shows up as a missing or extra shift on the next serial edge. The comparison against an independent model on every cycle catches each of these in the cycle the error first appears.

// File: rtl/entry_pkg.sv
package entry_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INIT  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_SHIFT = 2'd3
  } chain_act_e;
endpackage

// File: rtl/entry_edge_det.sv
module entry_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign fall_o = sig_q & ~sig_in;
endmodule

// File: rtl/entry_ctrl.sv
module entry_ctrl
  import entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       par_load,
  input  logic       ser_fall,
  input  logic       ser_en_n,
  input  logic       full,
  input  logic       out_ready,
  output chain_act_e act,
  output logic       proto_err
);
  logic take;
  assign take = full & out_ready;

  // Priority: reset, load, handover, shift
  always_comb begin
    if (rst)                                act = ACT_INIT;
    else if (par_load)                      act = ACT_LOAD;
    else if (take)                          act = ACT_INIT;
    else if (ser_fall && !ser_en_n && !full) act = ACT_SHIFT;
    else                                    act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= par_load & ser_fall;
  end

  // R5: a full register never shifts
  a_r5_no_shift_full: assert property (@(posedge clk) disable iff (rst)
    full |-> (act != ACT_SHIFT));
endmodule

// File: rtl/entry_chain.sv
module entry_chain
  import entry_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  chain_act_e        act,
  input  logic              ser_bit,
  input  logic [DATA_W-1:0] par_data,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_o
);
  localparam int TOP = DATA_W - 1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic shift_in;
    if (i == TOP) begin : g_top
      assign shift_in = ser_bit;
    end else begin : g_mid
      assign shift_in = data_o[i+1];
    end

    always_ff @(posedge clk) begin
      unique case (act)
        ACT_INIT:  data_o[i] <= (i == TOP);
        ACT_LOAD:  data_o[i] <= par_data[i];
        ACT_SHIFT: data_o[i] <= shift_in;
        default:   data_o[i] <= data_o[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_INIT:  flag_o <= 1'b0;
      ACT_LOAD:  flag_o <= 1'b1;
      ACT_SHIFT: flag_o <= data_o[0];
      default:   flag_o <= flag_o;
    endcase
  end

  // R4: the marker leaving stage 0 sets the flag stage
  a_r4_marker_to_flag: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SHIFT && data_o[0]) |=> flag_o);
  // R3: a shift moves each stage one place down
  a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SHIFT) |=> (data_o[TOP-1:0] == $past(data_o[TOP:1])));
endmodule

// File: rtl/nibble_entry_reg.sv
module nibble_entry_reg
  import entry_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_load,
  input  logic [DATA_W-1:0] par_data,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en_n,
  output logic              full_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              proto_err
);
  localparam logic [DATA_W-1:0] INIT_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic       ser_fall;
  logic       full;
  chain_act_e act;

  entry_edge_det i_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (ser_clk),
    .fall_o (ser_fall)
  );

  entry_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .par_load  (par_load),
    .ser_fall  (ser_fall),
    .ser_en_n  (ser_en_n),
    .full      (full),
    .out_ready (out_ready),
    .act       (act),
    .proto_err (proto_err)
  );

  entry_chain #(.DATA_W(DATA_W)) i_chain (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .ser_bit  (ser_data),
    .par_data (par_data),
    .data_o   (out_data),
    .flag_o   (full)
  );

  assign full_n    = ~full;
  assign out_valid = full;

  // R10: reset restores the empty state
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (full_n && !proto_err && out_data == INIT_VAL));
  // R2: parallel load captures the word and fills
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    par_load |=> (!full_n && out_data == $past(par_data)));
  // R7: handover re-initialises
  a_r7_reinit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !par_load) |=> (full_n && out_data == INIT_VAL));
  // R7: back-pressure holds the nibble
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !out_ready && !par_load) |=> (!full_n && $stable(out_data)));
  // R8: collision raises the flag next cycle
  a_r8_collision: assert property (@(posedge clk) disable iff (rst)
    (par_load && $past(ser_clk) && !ser_clk) |=> proto_err);
endmodule

// File: tb/test_nibble_entry_reg.sv
module test_nibble_entry_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_load = 1'b0;
  logic [3:0] par_data = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_en_n = 1'b0;
  logic       out_ready = 1'b0;
  logic       full_n, out_valid, proto_err;
  logic [3:0] out_data;

  always #10 clk = ~clk;

  nibble_entry_reg i_nibble_entry_reg (
    .clk(clk), .rst(rst), .par_load(par_load), .par_data(par_data),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en_n(ser_en_n),
    .full_n(full_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .proto_err(proto_err)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    armed = 0;
  bit    done = 0;

  // behavioural reference model
  bit       m_prev = 0;
  bit       m_full = 0;
  bit       m_perr = 0;
  bit [3:0] m_word = 4'b1000;
  bit       m_q[$];

  function automatic bit [3:0] shown();
    bit [3:0] v = '0;
    int k = m_q.size();
    if (m_full) return m_word;
    if (k < 4) v[3-k] = 1'b1;
    for (int j = 0; j < k; j++) v[4-k+j] = m_q[j];
    return v;
  endfunction

  always @(posedge clk) begin
    bit fall;
    fall = m_prev && !ser_clk;
    if (rst) begin
      m_prev = 0; m_full = 0; m_perr = 0; m_q.delete();
    end else begin
      m_perr = par_load && fall;
      m_prev = ser_clk;
      if (par_load) begin
        m_word = par_data; m_full = 1; m_q.delete();
      end else if (m_full && out_ready) begin
        m_full = 0; m_q.delete();
      end else if (fall && !ser_en_n && !m_full) begin
        m_q.push_back(ser_data);
        if (m_q.size() == 4) begin
          m_word = {m_q[3], m_q[2], m_q[1], m_q[0]};
          m_full = 1; m_q.delete();
        end
      end
    end
    armed = 1;
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      check("full_n", full_n, !m_full);
      check("out_valid", out_valid, m_full);
      check("out_data", out_data, shown());
      check("proto_err", proto_err, m_perr);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(bit b);
    ser_data = b; ser_clk = 1'b1; cyc();
    ser_clk = 1'b0; cyc();
  endtask

  task automatic ser_nib(bit [3:0] v); // v[0] sent first
    for (int i = 0; i < 4; i++) ser_bit(v[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1"; cyc(3);
    rst = 1'b0; cyc(2);

    // R3 / R4: serial fill, first bit to bit 0
    cur_req = "R3"; ser_nib(4'b1101);
    cur_req = "R4"; cyc();
    check("R4 nibble", out_data, 4'b1101);
    // R5: edges while full ignored
    cur_req = "R5"; ser_nib(4'b0010); cyc(2);
    // R7: handover after back-pressure
    cur_req = "R7"; out_ready = 1'b1; cyc(); out_ready = 1'b0; cyc(2);
    check("R7 reinit", out_data, 4'b1000);

    // R3: multi-nibble train with ready held high
    cur_req = "R3"; out_ready = 1'b1;
    ser_nib(4'b0110); ser_nib(4'b1001); ser_nib(4'b0111);
    cyc(2); out_ready = 1'b0;

    // R6: disabled serial input
    cur_req = "R6"; ser_en_n = 1'b1; ser_nib(4'b1111); ser_en_n = 1'b0; cyc();

    // R2: parallel load with back-pressure
    cur_req = "R2"; par_data = 4'b0101; par_load = 1'b1; cyc(); par_load = 1'b0; cyc(2);
    check("R2 word", out_data, 4'b0101);

    // R9: load during handover
    cur_req = "R9"; out_ready = 1'b1; par_data = 4'b1010; par_load = 1'b1; cyc();
    par_load = 1'b0; out_ready = 1'b0; cyc();
    check("R9 stays full", full_n, 0);
    out_ready = 1'b1; cyc(); out_ready = 1'b0; cyc();

    // R8: load collides with serial edge
    cur_req = "R8"; ser_data = 1'b1; ser_clk = 1'b1; cyc();
    ser_clk = 1'b0; par_data = 4'b0011; par_load = 1'b1; cyc();
    par_load = 1'b0; cyc(2);
    check("R8 word", out_data, 4'b0011);
    out_ready = 1'b1; cyc(); out_ready = 1'b0; cyc();

    // R10: reset in the middle of a serial nibble
    cur_req = "R10"; ser_bit(1'b1); ser_bit(1'b0);
    rst = 1'b1; cyc(); rst = 1'b0; cyc();
    check("R10 empty", out_data, 4'b1000);
    ser_nib(4'b1110); cyc();
    check("R10 refill", out_data, 4'b1110);
    out_ready = 1'b1; cyc(2); out_ready = 1'b0; cyc(2);

    finish_run();
  end
endmodule